// File: doc/BRIEF.md
# Character LCD Write Sequencer

This block drives a character LCD with an 8-bit parallel bus. It needs no processor. After a start pulse it sends four configuration commands and then a 16-character text line. It only writes. The read/write line stays at write, and the block never polls the panel's busy state. Each byte is shown on the data bus for one fixed timing window. The window has three parts: a setup span, then an enable pulse, then a hold span after enable falls. The panel latches the byte on the falling edge of enable.

Commands and characters are stored in one small constant ROM. The ROM output drives the data bus directly. A byte address register walks through the ROM, and it can hold, step forward or clear. A window counter measures the three timing spans, and it can also hold, step forward or clear. A three-state controller (idle, configure, print) chooses the operation for each path. It moves from configure to print once the last command byte is finished. When the final character window ends, it returns to idle and pulses done for one cycle. The three span lengths are parameters. Short values suit simulation, and values worth 10 ms, 58 ms and 3 ms at 50 MHz suit a real panel.

Top module: `lcd_write_seq`

## Requirements
- R1: While reset is held and after its release, enable, register select, read/write and done are all 0, and no byte is sent until start is seen.
- R2: A start pulse sampled in idle begins the sequence, and enable first rises SETUP_CYC clock edges after the edge that sampled start.
- R3: Exactly 20 bytes are sent, in this order: 0x38, 0x06, 0x0C, 0x01, then the 16 message bytes "HELLO WORLD!" padded with four spaces (0x20).
- R4: Register select is 0 while each of the four command bytes is sent and 1 while each of the 16 message bytes is sent. Read/write is 0 at all times.
- R5: Enable stays high for exactly HIGH_CYC cycles per byte. The data bus and register select do not change while enable is high or in the cycle enable falls.
- R6: Between two consecutive enable pulses, enable stays low for exactly HOLD_CYC + SETUP_CYC cycles. Each byte window is SETUP_CYC + HIGH_CYC + HOLD_CYC cycles long.
- R7: The ROM address holds for a whole byte window, steps by one at its end, and never exceeds 19.
- R8: Done is a single-cycle pulse that comes 20 full byte windows after the edge that sampled start. After it, the block is idle with enable and register select low.
- R9: Start has no effect while a sequence is running. No extra byte is sent and the timing does not change.
- R10: A start pulse after done runs the whole sequence again, identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a sequence when sampled in idle |
| lcd_rs_o | output | 1 | Register select: 0 for commands, 1 for characters |
| lcd_rw_o | output | 1 | Read/write, held at 0 (write) |
| lcd_e_o | output | 1 | Enable strobe; the panel latches data on its falling edge |
| lcd_db_o | output | 8 | Data bus, driven from the ROM |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Take the edge that samples start as edge zero. The first enable rise appears SETUP_CYC edges later. Every later rise follows the previous fall by HOLD_CYC + SETUP_CYC edges, each pulse lasts HIGH_CYC edges, and done appears after 20 × (SETUP_CYC + HIGH_CYC + HOLD_CYC) edges. The bench counts clock edges from the cycle it drives start, and it samples the ports on the falling clock edge. Each enable fall is compared with the next expected byte in a queue. Rise times and the done time are checked against those exact edge counts. A start pulse sent in the middle of a run must leave both the byte count and the done time unchanged.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {SEL_HOLD, SEL_INC, SEL_CLR} path_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_PRINT} seq_state_e;
endpackage

// File: rtl/lcd_msg_rom.sv
module lcd_msg_rom #(
  parameter int ADDR_W   = 5,
  parameter int MSG_LEN  = 16,
  parameter logic [8*MSG_LEN-1:0] MSG = "HELLO WORLD!    "
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);
  localparam int CFG_N = 4;

  function automatic logic [7:0] rom_byte(input int a);
    case (a)
      0: return 8'h38;  // 8-bit bus, two lines, 5x8 font
      1: return 8'h06;  // entry mode: increment, no shift
      2: return 8'h0C;  // display on, cursor off
      3: return 8'h01;  // clear display
      default:
        if (a < CFG_N + MSG_LEN) return MSG[8*(MSG_LEN-1-(a-CFG_N)) +: 8];
        else return 8'h20;
    endcase
  endfunction

  always_comb data_o = rom_byte(int'(addr_i));
endmodule

// File: rtl/lcd_addr_path.sv
module lcd_addr_path
  import lcd_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int LAST_ADDR = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  path_sel_e         sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else begin
      case (sel_i)
        SEL_INC: addr_q <= addr_q + 1'b1;
        SEL_CLR: addr_q <= '0;
        default: addr_q <= addr_q;
      endcase
    end
  end

  assign addr_o = addr_q;

  AST_ADDR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) addr_q <= LAST); // R7
endmodule

// File: rtl/lcd_delay_path.sv
module lcd_delay_path
  import lcd_seq_pkg::*;
#(
  parameter int CNT_W     = 22,
  parameter int CNT_LIMIT = 3549999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  path_sel_e        sel_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_LIMIT);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case (sel_i)
        SEL_INC: cnt_q <= cnt_q + 1'b1;
        SEL_CLR: cnt_q <= '0;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= LIMIT); // R6
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 22,
  parameter int CFG_LAST  = 3,
  parameter int LAST_ADDR = 19,
  parameter int CNT_LIMIT = 3549999
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output path_sel_e         addr_sel_o,
  output path_sel_e         cnt_sel_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(CFG_LAST);
  localparam logic [ADDR_W-1:0] LAST    = ADDR_W'(LAST_ADDR);
  localparam logic [CNT_W-1:0]  LIMIT   = CNT_W'(CNT_LIMIT);

  seq_state_e state_q, state_d;
  logic       done_q;
  logic       win_end, seq_end;

  assign win_end = (cnt_i == LIMIT);
  assign seq_end = (state_q == ST_PRINT) && win_end && (addr_i == LAST);

  always_comb begin
    state_d    = state_q;
    addr_sel_o = SEL_HOLD;
    cnt_sel_o  = SEL_INC;
    case (state_q)
      ST_IDLE: begin
        addr_sel_o = SEL_CLR;
        cnt_sel_o  = SEL_CLR;
        if (start_i) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (win_end) begin
          addr_sel_o = SEL_INC;
          cnt_sel_o  = SEL_CLR;
          if (addr_i == CFG_END) state_d = ST_PRINT;
        end
      end
      ST_PRINT: begin
        if (win_end) begin
          cnt_sel_o = SEL_CLR;
          if (addr_i == LAST) begin
            addr_sel_o = SEL_CLR;
            state_d    = ST_IDLE;
          end else begin
            addr_sel_o = SEL_INC;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= seq_end;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> !busy_o); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !win_end) |=> $stable(addr_i)); // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRINT && start_i && !seq_end) |=> state_q == ST_PRINT); // R9
endmodule

// File: rtl/lcd_write_seq.sv
module lcd_write_seq
  import lcd_seq_pkg::*;
#(
  parameter int SETUP_CYC = 500000,
  parameter int HIGH_CYC  = 2900000,
  parameter int HOLD_CYC  = 150000,
  parameter int CNT_W     = 22,
  parameter int MSG_LEN   = 16,
  parameter logic [8*MSG_LEN-1:0] MSG = "HELLO WORLD!    "
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_db_o,
  output logic       done_o
);
  localparam int CFG_N     = 4;
  localparam int N_BYTES   = CFG_N + MSG_LEN;
  localparam int ADDR_W    = $clog2(N_BYTES);
  localparam int LAST_ADDR = N_BYTES - 1;
  localparam int WIN_CYC   = SETUP_CYC + HIGH_CYC + HOLD_CYC;
  localparam logic [CNT_W-1:0]  E_ON    = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0]  E_OFF   = CNT_W'(SETUP_CYC + HIGH_CYC);
  localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(CFG_N - 1);

  path_sel_e         addr_sel, cnt_sel;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        rom_data;
  logic              busy;

  lcd_addr_path #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(addr_sel), .addr_o(addr)
  );

  lcd_delay_path #(.CNT_W(CNT_W), .CNT_LIMIT(WIN_CYC - 1)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(cnt_sel), .cnt_o(cnt)
  );

  lcd_msg_rom #(.ADDR_W(ADDR_W), .MSG_LEN(MSG_LEN), .MSG(MSG)) u_rom (
    .addr_i(addr), .data_o(rom_data)
  );

  lcd_seq_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_LAST(CFG_N - 1),
    .LAST_ADDR(LAST_ADDR), .CNT_LIMIT(WIN_CYC - 1)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .addr_i(addr), .cnt_i(cnt),
    .addr_sel_o(addr_sel), .cnt_sel_o(cnt_sel),
    .busy_o(busy), .done_o(done_o)
  );

  // Outputs decode from registered address and count only.
  assign lcd_e_o  = busy && (cnt >= E_ON) && (cnt < E_OFF);
  assign lcd_rs_o = busy && (addr > CFG_END);
  assign lcd_rw_o = 1'b0;
  assign lcd_db_o = rom_data;

  AST_DB_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && $past(lcd_e_o)) |-> ($stable(lcd_db_o) && $stable(lcd_rs_o))); // R5
  AST_DB_HOLD_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> $stable(lcd_db_o)); // R5
  AST_RS_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_e_o) |-> $stable(lcd_rs_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!lcd_e_o && !lcd_rs_o)); // R8
endmodule

// File: tb/tb_lcd_write_seq.sv
module tb_lcd_write_seq;
  localparam int SETUP = 3;
  localparam int HIGH  = 4;
  localparam int HOLD  = 2;
  localparam int WIN   = SETUP + HIGH + HOLD;
  localparam int NB    = 20;
  localparam logic [127:0] TXT = "HELLO WORLD!    ";

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic rs, rw, e, done;
  logic [7:0] db;

  always #4 clk = ~clk;

  lcd_write_seq #(.SETUP_CYC(SETUP), .HIGH_CYC(HIGH), .HOLD_CYC(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .lcd_rs_o(rs), .lcd_rw_o(rw), .lcd_e_o(e), .lcd_db_o(db), .done_o(done)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0, t0 = 0;
  logic [8:0] exp_q[$];
  bit first_pending = 1'b0;
  int rises = 0, done_cnt = 0, rw_bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor / scoreboard
  logic e_prev = 1'b0, done_prev = 1'b0;
  int high_len = 0, low_len = 0;
  logic [7:0] cap_db;
  logic cap_rs;
  bit unstable = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rw) rw_bad++;
      if (e && !e_prev) begin
        rises++;
        if (first_pending) begin
          chk(cyc - t0 == SETUP + 1, "R2", "first enable rise delay", cyc - t0, SETUP + 1);
          first_pending = 1'b0;
        end else begin
          chk(low_len == HOLD + SETUP, "R6", "enable low gap", low_len, HOLD + SETUP);
        end
        high_len = 1; cap_db = db; cap_rs = rs; unstable = 1'b0;
      end else if (e && e_prev) begin
        high_len++;
        if (db !== cap_db || rs !== cap_rs) unstable = 1'b1;
      end else if (!e && e_prev) begin
        logic [8:0] x;
        chk(high_len == HIGH, "R5", "enable high width", high_len, HIGH);
        chk(!unstable && db === cap_db, "R5", "data stable through fall", db, cap_db);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected extra byte", cap_db, 0);
        end else begin
          x = exp_q.pop_front();
          chk(cap_db === x[7:0], "R3", "byte value", cap_db, x[7:0]);
          chk(cap_rs === x[8], "R4", "register select", cap_rs, x[8]);
        end
        low_len = 1;
      end else begin
        low_len++;
      end
      if (done) begin
        done_cnt++;
        chk(cyc - t0 == NB * WIN + 1, "R8", "done timing", cyc - t0, NB * WIN + 1);
        chk(exp_q.size() == 0, "R3", "bytes left at done", exp_q.size(), 0);
      end
      if (done && done_prev) chk(1'b0, "R8", "done wider than one cycle", 2, 1);
      e_prev = e;
      done_prev = done;
    end
  end

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      0: return 8'h38;
      1: return 8'h06;
      2: return 8'h0C;
      3: return 8'h01;
      default: return TXT[8*(15-(i-4)) +: 8];
    endcase
  endfunction

  task automatic run_seq(input bit poke, input string req);
    int d0;
    @(negedge clk);
    for (int i = 0; i < NB; i++) exp_q.push_back({(i >= 4), exp_byte(i)});
    rises = 0;
    d0 = done_cnt;
    t0 = cyc;
    first_pending = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1;                      // during configure phase
      @(negedge clk); start = 1'b0;
      repeat (WIN * 8) @(negedge clk);
      start = 1'b1;                      // during print phase
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    chk(!e && !rs && !done, "R8", "idle after done", {e, rs, done}, 0);
    chk(rises == NB, req, "enable pulses per run", rises, NB);
    repeat (20) @(negedge clk);
    chk(rises == NB && !e, "R8", "no activity in idle", rises, NB);
  endtask

  initial begin
    #1;
    chk(!e && !rs && !rw && !done, "R1", "outputs in reset", {e, rs, rw, done}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk(!e && !rs && !done && rises == 0, "R1", "quiet before start", {e, rs, done}, 0);
    run_seq(1'b0, "R3");
    run_seq(1'b1, "R9");
    run_seq(1'b0, "R10");
    chk(rw_bad == 0, "R4", "read/write asserted cycles", rw_bad, 0);
    chk(done_cnt == 3, "R10", "completed runs", done_cnt, 3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    chk(1'b0, "R2", "watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule